// File: doc/BRIEF.md
# Packed Signed Multiply-Accumulate Unit

This block is a 128-bit SIMD datapath. It multiplies signed integer lanes of two source vectors, `a` and `b`, adds a third vector `c` that acts as an accumulator, and registers the result. A 3-bit mode field picks the lane widths and which source lanes take part. One extra bit picks between wrapping arithmetic and saturating arithmetic. The unit has no internal state other than its output register. It accepts one operation on any cycle where `in_valid` is high, and the result appears one cycle later with `out_valid`.

Some modes widen the result: narrow source lanes produce wider result lanes, so only half of the source products fit. These modes come in an even-lane form and an odd-lane form. The dual-product mode uses every word product instead: it adds two neighbouring products into one doubleword accumulator lane. Every product and every sum is formed at full precision before any clamping is applied.

Top module: `pmac_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by one clock. `result` loads only on a cycle with `in_valid` high and otherwise keeps its value.
- R3: Lane layout and mode 0 (word to word). Lane i of width w occupies bits [w*i+w-1 : w*i] of a vector. `op[2:0]`=0 gives eight 16-bit results, r[i] = a[i]*b[i] + c[i], using word lanes throughout.
- R4: Mode 1 (even words to doubleword): r[j] = a[2j]*b[2j] + c[j]. The sources are word lanes; c and r are four doubleword lanes.
- R5: Mode 2 (odd words to doubleword): r[j] = a[2j+1]*b[2j+1] + c[j], with c and r as doubleword lanes.
- R6: Mode 3 (doubleword to doubleword): four results, r[i] = a[i]*b[i] + c[i], using 32-bit lanes throughout.
- R7: Mode 4 (even doublewords to quadword): r[k] = a[2k]*b[2k] + c[k]. Mode 5 (odd doublewords to quadword): r[k] = a[2k+1]*b[2k+1] + c[k]. In both, c and r are 64-bit lanes.
- R8: Mode 6 (dual product): r[j] = a[2j]*b[2j] + a[2j+1]*b[2j+1] + c[j]. The sources are word lanes; c and r are doubleword lanes.
- R9: With `op[3]`=0, each result lane holds the low bits of the exact sum. With `op[3]`=1, a sum above the signed maximum of the result lane width gives that maximum (for example 0x7FFF for words), and a sum below the signed minimum gives that minimum (0x8000 for words).
- R10: The saturation decision uses the exact sum at full precision. This holds even when the products or the accumulator alone would overflow the result lane width.
- R11: Mode 7 is reserved. It gives an all-zero result, and `out_valid` still follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and op are presented this cycle |
| op | input | 4 | [2:0] mode, [3] saturate enable |
| a | input | 128 | First multiplicand vector |
| b | input | 128 | Second multiplicand vector |
| c | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Registered result vector |

## Verification
The clocked properties assume that `in_valid` is low while reset is asserted. They also assume that the operands and `op` are stable through the capturing edge, so the values seen by `$past` are the ones the register took. The bench drives all inputs on the falling edge and holds `in_valid` low until reset is released. The random stimulus draws across all eight op codes, with a bias toward extreme lane values so that the saturation paths are exercised. The directed cases cover each clamp direction, and an idle cycle with changed operands to confirm that the result is held.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

    typedef enum logic [2:0] {
        MODE_WW      = 3'd0,
        MODE_WD_EVEN = 3'd1,
        MODE_WD_ODD  = 3'd2,
        MODE_DD      = 3'd3,
        MODE_DQ_EVEN = 3'd4,
        MODE_DQ_ODD  = 3'd5,
        MODE_WD_DUAL = 3'd6,
        MODE_RSVD    = 3'd7
    } mode_e;

    // exact-sum width: 64-bit product + 64-bit accumulator needs 65 bits
    localparam int SUM_W = 66;

    // wrap or clamp an exact sum to a signed lane of w bits (w <= 64)
    function automatic logic [63:0] clamp_lane(
        input logic signed [SUM_W-1:0] v,
        input int unsigned             w,
        input logic                    sat
    );
        logic signed [SUM_W-1:0] hi;
        logic signed [SUM_W-1:0] lo;
        hi = $signed((SUM_W'(1) << (w - 1)) - SUM_W'(1));
        lo = ~hi;
        if (sat && (v > hi))
            return hi[63:0];
        else if (sat && (v < lo))
            return lo[63:0];
        else
            return v[63:0];
    endfunction

endpackage

// File: rtl/pmac_products.sv
module pmac_products #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]                a,
    input  logic [VEC_W-1:0]                b,
    output logic [VEC_W/16-1:0][31:0]       prod_w,
    output logic [VEC_W/32-1:0][63:0]       prod_d
);
    localparam int N16 = VEC_W / 16;
    localparam int N32 = VEC_W / 32;

    for (genvar i = 0; i < N16; i++) begin : g_word
        assign prod_w[i] = $signed(a[16*i +: 16]) * $signed(b[16*i +: 16]);
    end

    for (genvar j = 0; j < N32; j++) begin : g_dword
        assign prod_d[j] = $signed(a[32*j +: 32]) * $signed(b[32*j +: 32]);
    end

endmodule

// File: rtl/pmac_combine.sv
module pmac_combine
    import pmac_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [2:0]                  mode,
    input  logic                        sat,
    input  logic [VEC_W/16-1:0][31:0]   prod_w,
    input  logic [VEC_W/32-1:0][63:0]   prod_d,
    input  logic [VEC_W-1:0]            c,
    output logic [VEC_W-1:0]            res
);
    localparam int N16 = VEC_W / 16;
    localparam int N32 = VEC_W / 32;
    localparam int N64 = VEC_W / 64;

    logic [N16-1:0][15:0] ww_vec;
    logic [N32-1:0][31:0] wde_vec, wdo_vec, dual_vec, dd_vec;
    logic [N64-1:0][63:0] dqe_vec, dqo_vec;

    for (genvar i = 0; i < N16; i++) begin : g_w
        logic signed [SUM_W-1:0] s_ww;
        assign s_ww      = SUM_W'($signed(prod_w[i])) + SUM_W'($signed(c[16*i +: 16]));
        assign ww_vec[i] = 16'(clamp_lane(s_ww, 16, sat));
    end

    for (genvar j = 0; j < N32; j++) begin : g_d
        logic signed [SUM_W-1:0] acc, s_e, s_o, s_dual, s_dd;
        assign acc    = SUM_W'($signed(c[32*j +: 32]));
        assign s_e    = SUM_W'($signed(prod_w[2*j]))   + acc;
        assign s_o    = SUM_W'($signed(prod_w[2*j+1])) + acc;
        assign s_dual = SUM_W'($signed(prod_w[2*j])) + SUM_W'($signed(prod_w[2*j+1])) + acc;
        assign s_dd   = SUM_W'($signed(prod_d[j]))     + acc;
        assign wde_vec[j]  = 32'(clamp_lane(s_e,    32, sat));
        assign wdo_vec[j]  = 32'(clamp_lane(s_o,    32, sat));
        assign dual_vec[j] = 32'(clamp_lane(s_dual, 32, sat));
        assign dd_vec[j]   = 32'(clamp_lane(s_dd,   32, sat));
    end

    for (genvar k = 0; k < N64; k++) begin : g_q
        logic signed [SUM_W-1:0] acc, s_e, s_o;
        assign acc = SUM_W'($signed(c[64*k +: 64]));
        assign s_e = SUM_W'($signed(prod_d[2*k]))   + acc;
        assign s_o = SUM_W'($signed(prod_d[2*k+1])) + acc;
        assign dqe_vec[k] = clamp_lane(s_e, 64, sat);
        assign dqo_vec[k] = clamp_lane(s_o, 64, sat);
    end

    always_comb begin
        case (mode_e'(mode))
            MODE_WW:      res = ww_vec;
            MODE_WD_EVEN: res = wde_vec;
            MODE_WD_ODD:  res = wdo_vec;
            MODE_DD:      res = dd_vec;
            MODE_DQ_EVEN: res = dqe_vec;
            MODE_DQ_ODD:  res = dqo_vec;
            MODE_WD_DUAL: res = dual_vec;
            default:      res = '0;
        endcase
    end

endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
    import pmac_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic [VEC_W-1:0] c,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    localparam int N16 = VEC_W / 16;
    localparam int N32 = VEC_W / 32;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
    } stage_t;

    logic [N16-1:0][31:0] prod_w;
    logic [N32-1:0][63:0] prod_d;
    logic [VEC_W-1:0]     comb_res;
    stage_t               stage_d, stage_q;

    pmac_products #(.VEC_W(VEC_W)) u_products (
        .a      (a),
        .b      (b),
        .prod_w (prod_w),
        .prod_d (prod_d)
    );

    pmac_combine #(.VEC_W(VEC_W)) u_combine (
        .mode   (op[2:0]),
        .sat    (op[3]),
        .prod_w (prod_w),
        .prod_d (prod_d),
        .c      (c),
        .res    (comb_res)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid)
            stage_d.res = comb_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage_q <= '0;
        else
            stage_q <= stage_d;
    end

    assign out_valid = stage_q.vld;
    assign result    = stage_q.res;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2:0] == MODE_RSVD) |=> (result == '0));
    // R6
    dd_zero_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2:0] == MODE_DD && a[31:0] == 32'd0) |=> (result[31:0] == $past(c[31:0])));
    // R9
    ww_sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'b1000 && a[15:0] == 16'h8000 && b[15:0] == 16'h8000 && !c[15])
        |=> (result[15:0] == 16'h7FFF));

endmodule

// File: tb/pmac_unit_bench.sv
module pmac_unit_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   op = '0;
    logic [127:0] a = '0, b = '0, c = '0;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pmac_unit u_pmac_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .a(a), .b(b), .c(c), .out_valid(out_valid), .result(result)
    );

    function automatic logic signed [66:0] lane(input logic [127:0] v, input int w, input int idx);
        logic [127:0] sh;
        sh = v >> (w * idx);
        case (w)
            16:      return 67'($signed(sh[15:0]));
            32:      return 67'($signed(sh[31:0]));
            default: return 67'($signed(sh[63:0]));
        endcase
    endfunction

    function automatic logic [63:0] fit(input logic signed [66:0] v, input int w, input bit sat);
        logic signed [66:0] mx, mn;
        mx = (67'sd1 <<< (w - 1)) - 67'sd1;
        mn = -mx - 67'sd1;
        if (sat && v > mx) return mx[63:0];
        if (sat && v < mn) return mn[63:0];
        return v[63:0];
    endfunction

    function automatic logic [127:0] model(input logic [3:0] o, input logic [127:0] x,
                                           input logic [127:0] y, input logic [127:0] z);
        logic [127:0] r;
        logic signed [66:0] s;
        bit sat;
        r = '0;
        sat = o[3];
        case (o[2:0])
            3'd0: for (int i = 0; i < 8; i++) begin
                s = lane(x,16,i) * lane(y,16,i) + lane(z,16,i);
                r[16*i +: 16] = fit(s, 16, sat)[15:0];
            end
            3'd1, 3'd2: for (int j = 0; j < 4; j++) begin
                int src;
                src = 2*j + ((o[2:0] == 3'd2) ? 1 : 0);
                s = lane(x,16,src) * lane(y,16,src) + lane(z,32,j);
                r[32*j +: 32] = fit(s, 32, sat)[31:0];
            end
            3'd3: for (int j = 0; j < 4; j++) begin
                s = lane(x,32,j) * lane(y,32,j) + lane(z,32,j);
                r[32*j +: 32] = fit(s, 32, sat)[31:0];
            end
            3'd4, 3'd5: for (int k = 0; k < 2; k++) begin
                int src;
                src = 2*k + ((o[2:0] == 3'd5) ? 1 : 0);
                s = lane(x,32,src) * lane(y,32,src) + lane(z,64,k);
                r[64*k +: 64] = fit(s, 64, sat);
            end
            3'd6: for (int j = 0; j < 4; j++) begin
                s = lane(x,16,2*j) * lane(y,16,2*j) + lane(x,16,2*j+1) * lane(y,16,2*j+1) + lane(z,32,j);
                r[32*j +: 32] = fit(s, 32, sat)[31:0];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [3:0] o);
        case (o[2:0])
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4, 3'd5: return "R7";
            3'd6: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] o, input logic [127:0] x, input logic [127:0] y,
                          input logic [127:0] z, input string tag);
        logic [127:0] exp;
        exp = model(o, x, y, z);
        @(negedge clk);
        in_valid = 1'b1; op = o; a = x; b = y; c = z;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", {127'd0, out_valid}, 128'd1);
        check(tag.len() > 0 ? tag : req_of(o), result, exp);
    endtask

    function automatic logic [127:0] rnd_vec();
        logic [127:0] v;
        for (int i = 0; i < 8; i++) begin
            case ($urandom % 5)
                0: v[16*i +: 16] = 16'h7FFF;
                1: v[16*i +: 16] = 16'h8000;
                default: v[16*i +: 16] = 16'($urandom);
            endcase
        end
        if ($urandom % 4 == 0) v[63:0] = 64'h7FFF_FFFF_FFFF_FFFF;
        if ($urandom % 4 == 0) v[127:96] = 32'h8000_0000;
        return v;
    endfunction

    initial begin
        #4_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'd20240611));
        // R1: reset state
        #35;
        check("R1", {127'd0, out_valid}, 128'd0);
        check("R1", result, 128'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 simple word lanes, R9 wrap vs clamp
        run_op(4'h0, {8{16'd3}}, {8{16'hFFFE}}, {8{16'd10}}, "R3");
        run_op(4'h0, {8{16'h8000}}, {8{16'h8000}}, '0, "R9");
        run_op(4'h8, {8{16'h8000}}, {8{16'h8000}}, '0, "R9");
        run_op(4'h8, {8{16'h7FFF}}, {8{16'h8000}}, {8{16'h8000}}, "R9");
        // R4/R5 even/odd selection
        run_op(4'h1, 128'h0005_0002_0007_0003_0001_0004_0009_0006, {8{16'd2}}, {4{32'd100}}, "R4");
        run_op(4'h2, 128'h0005_0002_0007_0003_0001_0004_0009_0006, {8{16'd2}}, {4{32'd100}}, "R5");
        // R8/R10 dual product exceeds 32 bits only via the sum
        run_op(4'hE, {8{16'h8000}}, {8{16'h8000}}, {4{32'h7FFF_FFFF}}, "R10");
        run_op(4'h6, {8{16'h8000}}, {8{16'h8000}}, {4{32'h7FFF_FFFF}}, "R8");
        // R6 doubleword clamp low
        run_op(4'hB, {4{32'h7FFF_FFFF}}, {4{32'h8000_0000}}, {4{32'h8000_0000}}, "R6");
        // R7 quadword even/odd with saturating top
        run_op(4'hC, {4{32'h8000_0000}}, {4{32'h8000_0000}}, {2{64'h7FFF_FFFF_FFFF_FFFF}}, "R7");
        run_op(4'h5, 128'h1_0000_0002_0000_0003_0000_0004, {4{32'd5}}, {2{64'd1}}, "R7");
        // R11 reserved
        run_op(4'hF, {8{16'h1234}}, {8{16'h4321}}, {8{16'h5555}}, "R11");

        // R2 hold: idle cycle with new operands
        held = result;
        @(negedge clk);
        a = ~a; b = ~b; c = ~c; op = 4'h0;
        @(negedge clk);
        check("R2", {127'd0, out_valid}, 128'd0);
        check("R2", result, held);

        for (int n = 0; n < 400; n++) begin
            logic [3:0] o;
            o = 4'($urandom);
            run_op(o, rnd_vec(), rnd_vec(), rnd_vec(), "");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule